// File: doc/BRIEF.md
# Scaled float-to-integer converter

This unit turns an IEEE-754 single-precision operand into a 32-bit integer. Before rounding, it multiplies the operand by a power of two taken from a small scale field. A 4-bit conversion code fixes the rounding direction and whether the result is signed or unsigned, so no rounding-control register is involved. The unit reports an invalid-operation flag when the input is a NaN or when the scaled value does not fit the target range. It raises no trap.

The datapath is combinational and ends in one output register. An operand presented with `in_valid` high at a rising edge appears on `result` and `invalid` after that edge, with `out_valid` high for one cycle. Every input class is converted exactly: normal, subnormal (never flushed), signed zero, infinity and NaN.

Top module: `fcvt_scaled_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is `out_valid`=0, `result`=0 and `invalid`=0, whatever the other inputs are.
- R2: An operand accepted with `in_valid`=1 at an edge gives its outputs and `out_valid`=1 right after that edge. An edge with `in_valid`=0 clears `out_valid` and keeps `result` and `invalid` unchanged.
- R3: Code 8 gives a signed result rounded to nearest, with ties going to the even integer (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R4: Code 9 gives a signed result truncated toward zero (2.75 gives 2, -2.75 gives -2).
- R5: Code 10 gives a signed result rounded toward minus infinity. Code 11 gives a signed result rounded toward plus infinity.
- R6: The operand is multiplied by 2^t before rounding, where t is the unsigned 4-bit `scale` value from 0 to 15 (1.5 with t=4 gives 24; 1.0 with t=15 gives 32768).
- R7: Code 14 gives an unsigned result truncated toward zero. An operand that has its sign bit set and is not a NaN uses the signed rules of code 9 instead (-1.0 gives 0xFFFFFFFF, with `invalid`=0).
- R8: In signed conversion, a value above 2^31-1 saturates to 0x7FFFFFFF, and a value below -2^31 (or minus infinity) saturates to 0x80000000. Both set `invalid`=1. The value -2^31 itself is exact, with `invalid`=0.
- R9: In unsigned conversion, a value of 2^32 or more, or plus infinity, gives 0xFFFFFFFF with `invalid`=1. A value of 2^31 is exact.
- R10: A NaN of either sign gives 0x7FFFFFFF with `invalid`=1 under codes 8 to 11. Under code 14 it gives 0xFFFFFFFF with `invalid`=1.
- R11: Zeros of either sign give 0 with `invalid`=0. Subnormals are rounded exactly: a positive subnormal gives 1 under code 11, a negative subnormal gives 0xFFFFFFFF under code 10, and any subnormal gives 0 under codes 8 and 9.
- R12: The codes 0 to 7, 12, 13 and 15 are not conversions. They give `result`=0 and `invalid`=0 for any operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| op_code | input | 4 | Conversion code (8, 9, 10, 11, 14 convert) |
| scale | input | 4 | Power-of-two pre-scale exponent t |
| fp_in | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result register was loaded at the last edge |
| result | output | 32 | Integer result |
| invalid | output | 1 | NaN input or out-of-range value |

## Verification
The bench uses the default parameters: 8 exponent bits, 23 fraction bits, a 32-bit integer and a 4-bit scale. With these values the whole scale range can be driven. The overflow limits sit at reachable operands: 65536.0 with t=15 lands exactly on 2^31, and -2^31 with t=1 steps just past the negative limit. The smallest subnormal, even at the largest scale, still lies far below one half, so the floor, ceiling and nearest-even decisions at the bottom of the range are all exercised. The largest finite operand, infinities and NaNs of both signs take the saturation and flag paths under every conversion code.

// File: rtl/fcvt_pkg.sv
// Shared types and conversion code values for the scaled float-to-integer unit.
// Assumes a 4-bit conversion code; the values are fixed by the instruction
// encoding that the unit serves.
package fcvt_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_ZERO      = 2'd1,
        RM_DOWN      = 2'd2,
        RM_UP        = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic      conv;
        logic      to_unsigned;
        rnd_mode_e mode;
    } op_ctrl_t;

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_inf;
        logic is_zero;
    } fp_class_t;

    localparam logic [3:0] OPC_NEAREST = 4'd8;
    localparam logic [3:0] OPC_TRUNC   = 4'd9;
    localparam logic [3:0] OPC_FLOOR   = 4'd10;
    localparam logic [3:0] OPC_CEIL    = 4'd11;
    localparam logic [3:0] OPC_UTRUNC  = 4'd14;

endpackage

// File: rtl/fcvt_op_decode.sv
// Conversion code decoder.
// Maps the 4-bit code onto a rounding direction and a signed/unsigned choice.
// Assumes codes outside the five conversions must yield a quiet zero result.
module fcvt_op_decode
    import fcvt_pkg::*;
(
    input  logic [3:0] op_code,
    output op_ctrl_t   ctrl
);

    // Translate the code into control fields; unknown codes disable conversion.
    always_comb begin
        ctrl.conv        = 1'b1;
        ctrl.to_unsigned = 1'b0;
        ctrl.mode        = RM_ZERO;
        case (op_code)
            OPC_NEAREST: ctrl.mode = RM_NEAR_EVEN;
            OPC_TRUNC:   ctrl.mode = RM_ZERO;
            OPC_FLOOR:   ctrl.mode = RM_DOWN;
            OPC_CEIL:    ctrl.mode = RM_UP;
            OPC_UTRUNC: begin
                ctrl.mode        = RM_ZERO;
                ctrl.to_unsigned = 1'b1;
            end
            default:     ctrl.conv = 1'b0;
        endcase
    end

endmodule

// File: rtl/fcvt_unpack.sv
// Operand unpacker.
// Splits a binary floating-point word into class flags and a significand.
// Also computes the binary point position after the power-of-two pre-scale.
// Assumes subnormals carry an effective exponent of one and no hidden bit.
module fcvt_unpack
    import fcvt_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int MAN_W   = 23,
    parameter int SCALE_W = 4,
    parameter int SHIFT_W = EXP_W + 3
) (
    input  logic [EXP_W+MAN_W:0]     fp_in,
    input  logic [SCALE_W-1:0]       scale,
    output fp_class_t                cls,
    output logic [MAN_W:0]           sig,
    output logic signed [SHIFT_W-1:0] shift
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic [EXP_W-1:0] exp_eff;
    logic             exp_zero;
    logic             exp_ones;

    // Separate the fields and flag the reserved exponent values.
    always_comb begin
        exp_f    = fp_in[EXP_W+MAN_W-1:MAN_W];
        man_f    = fp_in[MAN_W-1:0];
        exp_zero = (exp_f == '0);
        exp_ones = (exp_f == '1);
        exp_eff  = exp_zero ? EXP_W'(1) : exp_f;
    end

    // Classify the operand.
    always_comb begin
        cls.sign    = fp_in[EXP_W+MAN_W];
        cls.is_nan  = exp_ones && (man_f != '0);
        cls.is_inf  = exp_ones && (man_f == '0);
        cls.is_zero = exp_zero && (man_f == '0);
    end

    // Significand with hidden bit, and the left-shift that places its LSB.
    always_comb begin
        sig   = {~exp_zero, man_f};
        shift = SHIFT_W'(int'(exp_eff) - BIAS - MAN_W + int'(scale));
    end

endmodule

// File: rtl/fcvt_magnitude.sv
// Magnitude builder.
// Aligns the significand to the binary point and rounds the magnitude in the
// selected direction. Out-of-window left shifts are flagged as huge.
// Assumes the sign is applied later; rounding directions that depend on the
// sign receive it here.
module fcvt_magnitude
    import fcvt_pkg::*;
#(
    parameter int SIG_W   = 24,
    parameter int INT_W   = 32,
    parameter int SHIFT_W = 11
) (
    input  logic [SIG_W-1:0]          sig,
    input  logic signed [SHIFT_W-1:0] shift,
    input  rnd_mode_e                 mode,
    input  logic                      sign,
    output logic [2*INT_W-1:0]        mag,
    output logic                      huge
);

    localparam int WIDE_W  = 2 * INT_W;
    localparam int LSH_MAX = WIDE_W - SIG_W;
    localparam int RWIN    = SIG_W + 2;
    localparam int RW      = SIG_W + RWIN;

    int               sh_i;
    logic [RW-1:0]    wide;
    logic [SIG_W-1:0] int_part;
    logic             rnd_bit;
    logic             sticky;
    logic             inc;

    // Right-shift path: integer part, round bit and sticky bit.
    always_comb begin
        sh_i     = int'(shift);
        wide     = '0;
        int_part = '0;
        rnd_bit  = 1'b0;
        sticky   = 1'b0;
        if (sh_i < 0) begin
            if (-sh_i >= RWIN) begin
                sticky = |sig;
            end else begin
                wide     = {sig, {RWIN{1'b0}}} >> (-sh_i);
                int_part = wide[RW-1:RWIN];
                rnd_bit  = wide[RWIN-1];
                sticky   = |wide[RWIN-2:0];
            end
        end
    end

    // Rounding increment for the selected direction.
    always_comb begin
        case (mode)
            RM_NEAR_EVEN: inc = rnd_bit & (sticky | int_part[0]);
            RM_DOWN:      inc = sign & (rnd_bit | sticky);
            RM_UP:        inc = ~sign & (rnd_bit | sticky);
            default:      inc = 1'b0;
        endcase
    end

    // Final magnitude: exact left shift, or rounded right-shift result.
    always_comb begin
        huge = 1'b0;
        mag  = '0;
        if (sh_i >= 0) begin
            if (sh_i > LSH_MAX) huge = 1'b1;
            else                mag  = WIDE_W'(sig) << sh_i;
        end else begin
            mag = WIDE_W'(int_part) + WIDE_W'(inc);
        end
    end

endmodule

// File: rtl/fcvt_saturate.sv
// Range check and sign application.
// Chooses signed or unsigned rules, saturates out-of-range values and raises
// the invalid flag. Assumes negative non-NaN operands under the unsigned code
// take the signed rules.
module fcvt_saturate #(
    parameter int INT_W = 32
) (
    input  logic [2*INT_W-1:0] mag,
    input  logic               huge,
    input  logic               sign,
    input  logic               is_nan,
    input  logic               is_inf,
    input  logic               conv,
    input  logic               to_unsigned,
    output logic [INT_W-1:0]   res,
    output logic               inv
);

    localparam int WIDE_W = 2 * INT_W;
    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] U_MAX   = '1;

    logic signed_rules;
    logic over;

    // Decide which rule set applies and whether the magnitude leaves range.
    always_comb begin
        signed_rules = ~to_unsigned | (sign & ~is_nan);
        if (is_inf || huge)             over = 1'b1;
        else if (!signed_rules)         over = (mag > WIDE_W'(U_MAX));
        else if (sign)                  over = (mag > WIDE_W'(NEG_MIN));
        else                            over = (mag > WIDE_W'(POS_MAX));
    end

    // Produce the integer result and the invalid flag.
    always_comb begin
        res = '0;
        inv = 1'b0;
        if (conv) begin
            if (is_nan) begin
                inv = 1'b1;
                res = signed_rules ? POS_MAX : U_MAX;
            end else if (over) begin
                inv = 1'b1;
                if (!signed_rules) res = U_MAX;
                else if (sign)     res = NEG_MIN;
                else               res = POS_MAX;
            end else if (signed_rules && sign) begin
                res = -mag[INT_W-1:0];
            end else begin
                res = mag[INT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fcvt_scaled_top.sv
// Scaled float-to-integer converter, top level.
// Combinational unpack, align/round and saturate stages feed one output
// register. Assumes a synchronous active-low reset and a one-cycle latency
// from an accepted operand to its result.
module fcvt_scaled_top
    import fcvt_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int MAN_W   = 23,
    parameter int INT_W   = 32,
    parameter int SCALE_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [3:0]             op_code,
    input  logic [SCALE_W-1:0]     scale,
    input  logic [EXP_W+MAN_W:0]   fp_in,
    output logic                   out_valid,
    output logic [INT_W-1:0]       result,
    output logic                   invalid
);

    localparam int SIG_W   = MAN_W + 1;
    localparam int SHIFT_W = EXP_W + 3;
    localparam int WIDE_W  = 2 * INT_W;
    localparam logic [INT_W-1:0] POS_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_MIN = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] U_MAX   = '1;

    op_ctrl_t                 dec_ctrl;
    fp_class_t                cls;
    logic [SIG_W-1:0]         sig;
    logic signed [SHIFT_W-1:0] shift;
    logic [WIDE_W-1:0]        mag;
    logic                     huge;
    logic [INT_W-1:0]         res_c;
    logic                     inv_c;

    fcvt_op_decode u_dec (
        .op_code (op_code),
        .ctrl    (dec_ctrl)
    );

    fcvt_unpack #(
        .EXP_W   (EXP_W),
        .MAN_W   (MAN_W),
        .SCALE_W (SCALE_W),
        .SHIFT_W (SHIFT_W)
    ) u_unpack (
        .fp_in (fp_in),
        .scale (scale),
        .cls   (cls),
        .sig   (sig),
        .shift (shift)
    );

    fcvt_magnitude #(
        .SIG_W   (SIG_W),
        .INT_W   (INT_W),
        .SHIFT_W (SHIFT_W)
    ) u_mag (
        .sig   (sig),
        .shift (shift),
        .mode  (dec_ctrl.mode),
        .sign  (cls.sign),
        .mag   (mag),
        .huge  (huge)
    );

    fcvt_saturate #(
        .INT_W (INT_W)
    ) u_sat (
        .mag         (mag),
        .huge        (huge),
        .sign        (cls.sign),
        .is_nan      (cls.is_nan),
        .is_inf      (cls.is_inf),
        .conv        (dec_ctrl.conv),
        .to_unsigned (dec_ctrl.to_unsigned),
        .res         (res_c),
        .inv         (inv_c)
    );

    // Output register: load on an accepted operand, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            invalid   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= res_c;
                invalid <= inv_c;
            end
        end
    end

    // R2
    issue_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(invalid));

    // R12
    no_conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !dec_ctrl.conv |=> result == '0 && !invalid);

    // R10
    nan_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && dec_ctrl.conv && !dec_ctrl.to_unsigned && cls.is_nan
        |=> result == POS_MAX && invalid);

    // R11
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && dec_ctrl.conv && cls.is_zero |=> result == '0 && !invalid);

    // R8
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && invalid |->
        (result == POS_MAX || result == NEG_MIN || result == U_MAX));

endmodule

// File: tb/fcvt_scaled_top_test.sv
`timescale 1ns/1ps
module fcvt_scaled_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [3:0]  scale = 4'd0;
    logic [31:0] fp_in = 32'h0;
    logic        out_valid;
    logic [31:0] result;
    logic        invalid;

    int n_chk = 0;
    int n_fail = 0;
    bit reported = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        inv;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    logic [31:0] last_res = 32'h0;
    logic        last_inv = 1'b0;

    always #2 clk = ~clk;

    fcvt_scaled_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .scale     (scale),
        .fp_in     (fp_in),
        .out_valid (out_valid),
        .result    (result),
        .invalid   (invalid)
    );

    task automatic check(input string tag, input logic [31:0] got_r, input logic got_i,
                         input logic [31:0] exp_r, input logic exp_i);
        n_chk++;
        if (got_r !== exp_r || got_i !== exp_i) begin
            n_fail++;
            $display("FAIL %s: result=%h invalid=%b expected result=%h invalid=%b",
                     tag, got_r, got_i, exp_r, exp_i);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    // Driver: present one operand and queue its expected outcome.
    task automatic send(input logic [31:0] f, input logic [3:0] op, input logic [3:0] t,
                        input logic [31:0] er, input logic ei, input string tag);
        exp_t e;
        @(negedge clk);
        fp_in    = f;
        op_code  = op;
        scale    = t;
        in_valid = 1'b1;
        e.res = er;
        e.inv = ei;
        e.tag = tag;
        sb_q.push_back(e);
        last_res = er;
        last_inv = ei;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            fp_in    = 32'h7FC00000;
            op_code  = 4'd8;
        end
    endtask

    // Monitor: pop and compare whenever a result is presented.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R2: unexpected out_valid result=%h expected no result", result);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, result, invalid, e.res, e.inv);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        // R1: reset dominates a valid operand
        in_valid = 1'b1;
        fp_in    = 32'h7F800000;
        op_code  = 4'd8;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", result, invalid, 32'h0, 1'b0);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: out_valid=%b expected=0", out_valid);
        end
        in_valid = 1'b0;
        rst_n    = 1'b1;
        idle(2);

        // R3 round to nearest even
        send(32'h40200000, 4'd8, 4'd0, 32'd2, 1'b0, "R3");
        send(32'h40600000, 4'd8, 4'd0, 32'd4, 1'b0, "R3");
        send(32'hC0200000, 4'd8, 4'd0, 32'hFFFFFFFE, 1'b0, "R3");
        send(32'h3F000000, 4'd8, 4'd0, 32'd0, 1'b0, "R3");
        send(32'h3FC00000, 4'd8, 4'd0, 32'd2, 1'b0, "R3");
        // R4 truncate
        send(32'h40300000, 4'd9, 4'd0, 32'd2, 1'b0, "R4");
        send(32'hC0300000, 4'd9, 4'd0, 32'hFFFFFFFE, 1'b0, "R4");
        // R5 floor / ceil
        send(32'hC0300000, 4'd10, 4'd0, 32'hFFFFFFFD, 1'b0, "R5");
        send(32'h40300000, 4'd10, 4'd0, 32'd2, 1'b0, "R5");
        send(32'h40100000, 4'd11, 4'd0, 32'd3, 1'b0, "R5");
        send(32'hC0100000, 4'd11, 4'd0, 32'hFFFFFFFE, 1'b0, "R5");
        // R6 pre-scale
        send(32'h3FC00000, 4'd9, 4'd4, 32'd24, 1'b0, "R6");
        send(32'h3F400000, 4'd8, 4'd1, 32'd2, 1'b0, "R6");
        send(32'h3F800000, 4'd9, 4'd15, 32'h00008000, 1'b0, "R6");
        idle(3);
        // R2: idle edges leave outputs unchanged
        n_chk++;
        if (out_valid !== 1'b0 || result !== last_res || invalid !== last_inv) begin
            n_fail++;
            $display("FAIL R2: out_valid=%b result=%h invalid=%b expected 0 %h %b",
                     out_valid, result, invalid, last_res, last_inv);
        end
        // R7 unsigned truncate and negative operands
        send(32'h4F000000, 4'd14, 4'd0, 32'h80000000, 1'b0, "R7");
        send(32'hBF800000, 4'd14, 4'd0, 32'hFFFFFFFF, 1'b0, "R7");
        send(32'hC0300000, 4'd14, 4'd0, 32'hFFFFFFFE, 1'b0, "R7");
        send(32'h47800000, 4'd14, 4'd15, 32'h80000000, 1'b0, "R7");
        // R8 signed saturation
        send(32'h4F000000, 4'd9, 4'd0, 32'h7FFFFFFF, 1'b1, "R8");
        send(32'hCF000000, 4'd9, 4'd0, 32'h80000000, 1'b0, "R8");
        send(32'hCF000000, 4'd9, 4'd1, 32'h80000000, 1'b1, "R8");
        send(32'h47800000, 4'd8, 4'd15, 32'h7FFFFFFF, 1'b1, "R8");
        send(32'h7F7FFFFF, 4'd10, 4'd0, 32'h7FFFFFFF, 1'b1, "R8");
        send(32'hFF800000, 4'd9, 4'd0, 32'h80000000, 1'b1, "R8");
        send(32'hFF800000, 4'd14, 4'd0, 32'h80000000, 1'b1, "R8");
        send(32'h7F800000, 4'd8, 4'd0, 32'h7FFFFFFF, 1'b1, "R8");
        // R9 unsigned saturation
        send(32'h4F800000, 4'd14, 4'd0, 32'hFFFFFFFF, 1'b1, "R9");
        send(32'h7F800000, 4'd14, 4'd0, 32'hFFFFFFFF, 1'b1, "R9");
        // R10 NaN
        send(32'h7FC00000, 4'd8, 4'd0, 32'h7FFFFFFF, 1'b1, "R10");
        send(32'hFFC00000, 4'd11, 4'd0, 32'h7FFFFFFF, 1'b1, "R10");
        send(32'hFFC00000, 4'd14, 4'd0, 32'hFFFFFFFF, 1'b1, "R10");
        // R11 zeros and subnormals
        send(32'h00000000, 4'd8, 4'd0, 32'd0, 1'b0, "R11");
        send(32'h80000000, 4'd10, 4'd0, 32'd0, 1'b0, "R11");
        send(32'h00000001, 4'd11, 4'd15, 32'd1, 1'b0, "R11");
        send(32'h80000001, 4'd10, 4'd0, 32'hFFFFFFFF, 1'b0, "R11");
        send(32'h00000001, 4'd8, 4'd15, 32'd0, 1'b0, "R11");
        send(32'h00400000, 4'd9, 4'd15, 32'd0, 1'b0, "R11");
        // R12 non-conversion codes
        send(32'h3F800000, 4'd12, 4'd0, 32'd0, 1'b0, "R12");
        send(32'h7FC00000, 4'd0, 4'd0, 32'd0, 1'b0, "R12");
        send(32'h7F800000, 4'd15, 4'd3, 32'd0, 1'b0, "R12");
        send(32'h4F800000, 4'd13, 4'd0, 32'd0, 1'b0, "R12");
        send(32'h40600000, 4'd7, 4'd0, 32'd0, 1'b0, "R12");
        idle(4);

        n_chk++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
        end
        report();
        $finish;
    end

endmodule